// File: doc/BRIEF.md
# Command Packet Receive FIFO

This block holds a command packet that a host pushes, one byte per write, into a shallow byte-wide queue. A local microprocessor takes the bytes out, oldest first, through one read port. The read port shows the oldest stored byte at all times, and a read strobe advances past it. When nothing is stored, the read port shows all ones (FFh).

The packet length is programmable. On each rising edge of a data-request input, the low four bits of a byte-count input are captured as the fill threshold. This lets the same queue collect parameter strings shorter than a full 12-byte packet. When the stored count reaches the threshold, the block marks the packet complete and refuses any further host bytes until the queue has been drained. Three flags report the state: an active-low not-empty flag, an active-low transfer-end flag and an active-high packet-complete flag. An interrupt request is raised while data is present and the interrupt is enabled.

Top module: `cmd_pkt_fifo`

## Requirements
- R1: The queue holds up to 12 bytes and returns them on the read port in the order the host wrote them. The read port shows the oldest stored byte, and a read strobe removes it at the next clock edge.
- R2: While the queue is empty, the read port shows FFh. A read strobe while empty changes no flag and no stored content.
- R3: On a 0-to-1 transition of `drq_i`, the low 4 bits of `byte_count_i` become the threshold. The upper bits are ignored. Holding `drq_i` high and then changing `byte_count_i` does not change the threshold.
- R4: After reset the threshold is 12. A captured value of 0, or any value above 12, is used as 12.
- R5: When an accepted host write brings the stored count to the threshold, `pkt_done_o` goes to 1 and `xfer_end_n_o` goes to 0 from the clock edge of that write.
- R6: While `pkt_done_o` is 1, host writes are ignored: the stored bytes and the count do not change.
- R7: `not_empty_n_o` goes to 0 from the edge of the first accepted write. It returns to 1 from the edge at which the last byte is read. Draining the queue also clears `pkt_done_o` and returns `xfer_end_n_o` to 1.
- R8: `irq_o` is 1 exactly when `irq_en_i` is 1 and `not_empty_n_o` is 0.
- R9: A host write and a read strobe in the same cycle on a non-empty, incomplete queue leave the count unchanged. The new byte goes behind the stored ones.
- R10: After reset the queue is empty, `not_empty_n_o` and `xfer_end_n_o` are 1, `pkt_done_o` is 0 and the read port shows FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe for the data port |
| host_wdata_i | input | 8 | Host write byte |
| up_rd_i | input | 1 | Microprocessor read strobe |
| up_rdata_o | output | 8 | Oldest stored byte, or FFh when empty |
| drq_i | input | 1 | Data-request level; its rising edge captures the threshold |
| byte_count_i | input | 16 | Byte count; the low 4 bits are captured as the threshold |
| irq_en_i | input | 1 | Enable for the not-empty interrupt |
| not_empty_n_o | output | 1 | Active-low not-empty flag |
| xfer_end_n_o | output | 1 | Active-low transfer-end flag |
| pkt_done_o | output | 1 | Packet-complete flag; host writes are refused while it is high |
| irq_o | output | 1 | Interrupt request |

## Verification
The queue is first filled to the default 12-byte threshold and then to captured thresholds of 5, 0 and 14. This separates correct capture from clamping, and correct capture from a threshold that stays fixed. Writes made after completion carry distinct marker bytes, so a wrongly accepted byte shows up later in the scoreboard order. A change of the byte count while the request input stays high checks edge-only capture. Reads of an empty queue, and a combined write-and-read cycle on a partly filled queue, check the FFh value and that the count holds.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

    // Value shown on the read port while nothing is stored
    localparam logic [7:0] CPF_EMPTY_BYTE = 8'hFF;

    // Map a raw captured threshold onto 1..depth; 0 and oversize fall back to depth
    function automatic int unsigned cpf_clamp_thr(input int unsigned raw,
                                                  input int unsigned depth);
        if (raw == 0 || raw > depth) begin
            return depth;
        end
        return raw;
    endfunction

    // Circular pointer advance over 0..depth-1
    function automatic int unsigned cpf_ptr_next(input int unsigned ptr,
                                                 input int unsigned depth);
        if (ptr >= depth - 1) begin
            return 0;
        end
        return ptr + 1;
    endfunction

endpackage

// File: rtl/cpf_thresh.sv
module cpf_thresh
    import cpf_pkg::*;
#(
    parameter int unsigned DEPTH    = 12,
    parameter int unsigned THR_BITS = 4,
    parameter int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                drq_i,
    input  logic [THR_BITS-1:0] raw_thr_i,
    output logic [CNT_W-1:0]    thr_o
);

    typedef struct packed {
        logic             drq;
        logic [CNT_W-1:0] thr;
    } thr_state_t;

    thr_state_t st_d, st_q;
    logic       drq_rise;

    always_comb begin
        st_d     = st_q;
        drq_rise = drq_i && !st_q.drq;
        st_d.drq = drq_i;
        if (drq_rise) begin
            st_d.thr = CNT_W'(cpf_clamp_thr(int'(raw_thr_i), DEPTH));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.drq <= 1'b0;
            st_q.thr <= CNT_W'(DEPTH);
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_o = st_q.thr;

    AST_THR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.thr != '0) && (st_q.thr <= CNT_W'(DEPTH))); // R4

    AST_THR_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(drq_i && !st_q.drq) |=> $stable(st_q.thr)); // R3

endmodule

// File: rtl/cpf_store.sv
module cpf_store
    import cpf_pkg::*;
#(
    parameter int unsigned DEPTH  = 12,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] head_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [DATA_W-1:0] slot_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.wr_ptr = PTR_W'(cpf_ptr_next(int'(st_q.wr_ptr), DEPTH));
        end
        if (pop_i) begin
            st_d.rd_ptr = PTR_W'(cpf_ptr_next(int'(st_q.rd_ptr), DEPTH));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // One register per slot, each loaded by its own decoded write enable
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic slot_we;
        assign slot_we = push_i && (st_q.wr_ptr == PTR_W'(gi));
        always_ff @(posedge clk) begin
            if (slot_we) begin
                slot_q[gi] <= wdata_i;
            end
        end
    end

    assign head_o = slot_q[st_q.rd_ptr];

    AST_PTR_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr_ptr < PTR_W'(DEPTH)) && (st_q.rd_ptr < PTR_W'(DEPTH))); // R1

    AST_RD_PTR_MOVES_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_i |=> $stable(st_q.rd_ptr)); // R2

endmodule

// File: rtl/cpf_ctrl.sv
module cpf_ctrl #(
    parameter int unsigned DEPTH = 12,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_i,
    input  logic             up_rd_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             push_o,
    output logic             pop_o,
    output logic             empty_o,
    output logic             done_o,
    output logic             not_empty_n_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             done;
        logic             nempty_n;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        room;
    logic        holding;

    always_comb begin
        st_d    = st_q;
        room    = (st_q.count != CNT_W'(DEPTH));
        holding = (st_q.count != '0);
        push_o  = host_wr_i && !st_q.done && room;
        pop_o   = up_rd_i && holding;

        unique case ({push_o, pop_o})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase

        if (st_d.count == '0) begin
            st_d.done = 1'b0;
        end else if (push_o && (st_d.count >= thr_i)) begin
            st_d.done = 1'b1;
        end

        st_d.nempty_n = (st_d.count == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count    <= '0;
            st_q.done     <= 1'b0;
            st_q.nempty_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty_o       = !holding;
    assign done_o        = st_q.done;
    assign not_empty_n_o = st_q.nempty_n;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH)); // R1

    AST_REJECT_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && host_wr_i && !up_rd_i) |=> $stable(st_q.count)); // R6

    AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!holding && up_rd_i && !host_wr_i) |=> (st_q.count == '0)); // R2

    AST_SIMUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && pop_o) |=> $stable(st_q.count)); // R9

    AST_DONE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(push_o)); // R5

    AST_FLAG_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.nempty_n |-> (st_q.count != '0)); // R7

endmodule

// File: rtl/cmd_pkt_fifo.sv
module cmd_pkt_fifo
    import cpf_pkg::*;
#(
    parameter int unsigned DEPTH    = 12,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned BCNT_W   = 16,
    parameter int unsigned THR_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic              up_rd_i,
    output logic [DATA_W-1:0] up_rdata_o,
    input  logic              drq_i,
    input  logic [BCNT_W-1:0] byte_count_i,
    input  logic              irq_en_i,
    output logic              not_empty_n_o,
    output logic              xfer_end_n_o,
    output logic              pkt_done_o,
    output logic              irq_o
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  thr;
    logic              push;
    logic              pop;
    logic              empty;
    logic              done;
    logic              nempty_n;
    logic [DATA_W-1:0] head;

    cpf_thresh #(
        .DEPTH    (DEPTH),
        .THR_BITS (THR_BITS),
        .CNT_W    (CNT_W)
    ) u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .drq_i     (drq_i),
        .raw_thr_i (byte_count_i[THR_BITS-1:0]),
        .thr_o     (thr)
    );

    cpf_ctrl #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr_i     (host_wr_i),
        .up_rd_i       (up_rd_i),
        .thr_i         (thr),
        .push_o        (push),
        .pop_o         (pop),
        .empty_o       (empty),
        .done_o        (done),
        .not_empty_n_o (nempty_n)
    );

    cpf_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .wdata_i (host_wdata_i),
        .head_o  (head)
    );

    assign up_rdata_o    = empty ? DATA_W'(CPF_EMPTY_BYTE) : head;
    assign not_empty_n_o = nempty_n;
    assign pkt_done_o    = done;
    assign xfer_end_n_o  = !done;
    assign irq_o         = irq_en_i && !nempty_n;

    AST_EMPTY_SHOWS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        nempty_n |-> (up_rdata_o == DATA_W'(CPF_EMPTY_BYTE))); // R2

    AST_DONE_IMPLIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !nempty_n); // R7

endmodule

// File: tb/cmd_pkt_fifo_bench.sv
module cmd_pkt_fifo_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        up_rd = 1'b0;
    logic [7:0]  up_rdata;
    logic        drq = 1'b0;
    logic [15:0] byte_count = '0;
    logic        irq_en = 1'b0;
    logic        not_empty_n, xfer_end_n, pkt_done, irq;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [7:0] exp_q[$];
    int  m_thr  = DEPTH;
    bit  m_done = 1'b0;
    string rd_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_pkt_fifo u_cmd_pkt_fifo (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr_i     (host_wr),
        .host_wdata_i  (host_wdata),
        .up_rd_i       (up_rd),
        .up_rdata_o    (up_rdata),
        .drq_i         (drq),
        .byte_count_i  (byte_count),
        .irq_en_i      (irq_en),
        .not_empty_n_o (not_empty_n),
        .xfer_end_n_o  (xfer_end_n),
        .pkt_done_o    (pkt_done),
        .irq_o         (irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read result against the scoreboard head
    always @(negedge clk) begin
        #1;
        if (up_rd) begin
            if (exp_q.size() == 0) begin
                check(up_rdata == 8'hFF, {rd_tag, " empty read"}, up_rdata, 8'hFF);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(up_rdata == e, {rd_tag, " read order"}, up_rdata, e);
                if (exp_q.size() == 0) m_done = 1'b0;
            end
        end
    end

    // Driver: host write; pushes the expected byte when the model accepts it
    task automatic hwrite(input logic [7:0] b, input bit with_read = 1'b0);
        bit acc;
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = b;
        up_rd      = with_read;
        acc = !m_done && (exp_q.size() < DEPTH);
        if (acc) begin
            exp_q.push_back(b);
            if (exp_q.size() >= m_thr) m_done = 1'b1;
        end
        @(negedge clk);
        host_wr = 1'b0;
        up_rd   = 1'b0;
    endtask

    task automatic uread();
        @(negedge clk);
        up_rd = 1'b1;
        @(negedge clk);
        up_rd = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) uread();
    endtask

    task automatic check_flags(input string tag);
        #2;
        check(pkt_done == m_done, {tag, " pkt_done"}, pkt_done, m_done);
        check(xfer_end_n == !m_done, {tag, " xfer_end_n"}, xfer_end_n, !m_done);
        check(not_empty_n == (exp_q.size() == 0), {tag, " not_empty_n"},
              not_empty_n, exp_q.size() == 0);
        check(irq == (irq_en && exp_q.size() != 0), {tag, " irq"}, irq,
              irq_en && exp_q.size() != 0);
    endtask

    task automatic capture_thr(input logic [15:0] v);
        @(negedge clk);
        drq        = 1'b0;
        @(negedge clk);
        byte_count = v;
        drq        = 1'b1;
        m_thr = (v[3:0] == 0 || v[3:0] > DEPTH) ? DEPTH : int'(v[3:0]);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check_flags("R10");
        check(up_rdata == 8'hFF, "R10 read port", up_rdata, 8'hFF);

        // R2 empty read returns FFh and changes nothing
        rd_tag = "R2";
        uread();
        check_flags("R2");

        // R8 interrupt follows enable and not-empty
        rd_tag = "R1";
        hwrite(8'h3C);
        check_flags("R8 disabled");
        irq_en = 1'b1;
        check_flags("R8 enabled");
        uread();
        check_flags("R7 drained");

        // R5/R6 default threshold of 12 (R4)
        for (int i = 0; i < 11; i++) hwrite(8'h10 + 8'(i));
        check_flags("R4 default not yet");
        hwrite(8'h1B);
        check_flags("R5 full packet");
        hwrite(8'hEE);
        hwrite(8'hED);
        check_flags("R6 rejected");
        drain();
        check_flags("R7 after full drain");

        // R3 captured threshold of 5 from the low nibble only
        capture_thr(16'hAB05);
        for (int i = 0; i < 4; i++) hwrite(8'h50 + 8'(i));
        check_flags("R3 thr5 at 4");
        hwrite(8'h54);
        check_flags("R3 thr5 reached");
        hwrite(8'hE1);
        check_flags("R6 thr5 reject");
        drain();

        // R3 level held high: changing the count input does not recapture
        byte_count = 16'h0003;
        for (int i = 0; i < 3; i++) hwrite(8'h60 + 8'(i));
        check_flags("R3 no recapture");
        hwrite(8'h63);
        hwrite(8'h64);
        check_flags("R3 still 5");
        drain();

        // R4 zero and oversize fall back to 12
        capture_thr(16'h0000);
        for (int i = 0; i < 11; i++) hwrite(8'h70 + 8'(i));
        check_flags("R4 zero at 11");
        hwrite(8'h7B);
        check_flags("R4 zero at 12");
        drain();
        capture_thr(16'h000E);
        for (int i = 0; i < 12; i++) hwrite(8'h80 + 8'(i));
        check_flags("R4 oversize at 12");
        drain();

        // R9 simultaneous write and read keeps the count
        rd_tag = "R9";
        capture_thr(16'h000C);
        hwrite(8'hA0);
        hwrite(8'hA1);
        hwrite(8'hA2);
        hwrite(8'hA3, 1'b1);
        hwrite(8'hA4, 1'b1);
        check_flags("R9 count held");
        for (int i = 0; i < 9; i++) hwrite(8'hB0 + 8'(i));
        check_flags("R9 reaches 12");
        drain();
        check_flags("R9 drained");

        drq = 1'b0;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule